// File: doc/BRIEF.md
# Vertical-Four Tiled Pixel Packer

This block turns a strip of 10-bit image samples, four rows tall, into 128-bit memory words using a column-first tiled order. Each input beat carries one column of four vertically adjacent samples. The packer places the four samples of a column next to each other, then moves right to the next column. After a programmed number of columns it closes the word and starts the following column in a fresh word.

A 64-bit layout descriptor sets the scan type, the column repeat count and the trailing pad width. The descriptor is loaded only while the packer is idle, meaning no column is waiting in a partial word and no word is waiting at the output. Each descriptor is checked when it is loaded. A rejected descriptor raises an error flag and stops all input until a legal descriptor is loaded.

A strip may end in the middle of a word. An input end marker then flushes the partial word with zeros in its empty slots, and the output end marker is raised on that word. Both the input and the output use a valid/ready handshake. A stalled output holds its word unchanged and stops the input.

Top module: `vtile_packer`

## Requirements
- R1: Descriptor bits 7:0 select the scan. Only value 1 (vertical-four) is legal. Value 0 and every value from 2 to 255 set `cfg_err` after the descriptor is loaded.
- R2: A loaded descriptor with any bit set in 35:20 or in 55:37 sets `cfg_err`.
- R3: A loaded descriptor with bit 36 (compressed layout) set sets `cfg_err`.
- R4: Bits 15:8 hold the column repeat count `reps` and bits 19:16 hold the pad width `pad`. The descriptor is legal only when `reps` >= 1 and 40*`reps`+`pad` <= 128. Otherwise `cfg_err` is set. While `cfg_err` is high, `in_ready` stays low.
- R5: After reset, `out_valid`, `cfg_err` and `in_ready` are low. No input is accepted, and no word is produced, until a legal descriptor has been loaded.
- R6: Within a word, the sample in row r of the word's c-th column sits at bits [(4c+r)*10 +: 10]. Row r of an input column is `in_col[r*10 +: 10]`.
- R7: Every output bit at or above position 120, and every slot past the last written column, is zero. The pad bits sit at the top of the word.
- R8: A word is emitted once `reps` columns have been taken. The next column starts a new word at column slot 0.
- R9: A column taken with `in_last` high closes the current word at once, with its empty slots zero. `out_last` is high on that word, and only on it, in the cycle after the transfer.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. No sample is lost, duplicated or reordered.
- R11: A descriptor is loaded only when a word is neither partly filled nor waiting at the output. Otherwise `cfg_valid` has no effect on `cfg_err` or on the layout. In a cycle where a descriptor is loaded, `in_ready` is low.

Additional limits on `reps` and `pad`, beyond those in R4, are not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Descriptor load request |
| cfg_desc | input | 64 | Layout descriptor |
| cfg_err | output | 1 | Last loaded descriptor was rejected |
| in_valid | input | 1 | Input column valid |
| in_ready | output | 1 | Packer accepts a column |
| in_col | input | 40 | Four samples, row 0 in the low bits |
| in_last | input | 1 | Column ends the strip |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts the word |
| out_data | output | 128 | Packed memory word |
| out_last | output | 1 | Word closes the strip |

## Verification
A wrong column counter shows up at the output within one word. The wrong number of columns is packed, or a sample lands in the wrong 10-bit slot, or a word closes early or late. A word comparison against the arithmetic model catches this on the first affected word.

If the slot registers are not cleared, stale samples appear in the zero-filled slots of the next flushed word. If the idle detection is faulty, a descriptor loaded mid-word changes the error flag or the word length one cycle after the ignored request. Output-stall faults show up as a word that changes while held. Lost-sample faults show up as a count mismatch when the strip is drained.

// File: rtl/vtile_pkg.sv
package vtile_pkg;
  localparam int DESC_W = 64;
  localparam int DIR_LO = 0;
  localparam int REP_LO = 8;
  localparam int PAD_LO = 16;
  localparam int CMP_BIT = 36;
  localparam logic [7:0] DIR_VERT4 = 8'd1;
  localparam logic [DESC_W-1:0] RSVD_MASK = 64'h00FF_FFEF_FFF0_0000;

  typedef struct packed {
    logic       legal;
    logic [7:0] reps;
    logic [3:0] pad;
  } layout_t;
endpackage

// File: rtl/vtile_desc_check.sv
module vtile_desc_check
  import vtile_pkg::*;
#(
  parameter int COL_BITS = 40,
  parameter int WORD_W   = 128
) (
  input  logic [DESC_W-1:0] desc,
  output layout_t           lay
);
  int   span;
  logic bad_dir, bad_rsvd, bad_cmp, bad_size;

  always_comb begin
    lay.reps = desc[REP_LO +: 8];
    lay.pad  = desc[PAD_LO +: 4];
    span     = int'(lay.reps) * COL_BITS + int'(lay.pad);
    bad_dir  = desc[DIR_LO +: 8] != DIR_VERT4;
    bad_rsvd = |(desc & RSVD_MASK);
    bad_cmp  = desc[CMP_BIT];
    bad_size = (lay.reps == 8'd0) || (span > WORD_W);
    lay.legal = !(bad_dir || bad_rsvd || bad_cmp || bad_size);
  end
endmodule

// File: rtl/vtile_col_accum.sv
module vtile_col_accum #(
  parameter int COL_BITS = 40,
  parameter int MAX_COLS = 3,
  parameter int CNT_W    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         take,
  input  logic                         last_in,
  input  logic [CNT_W-1:0]             last_col,
  input  logic [COL_BITS-1:0]          col_in,
  output logic                         word_done,
  output logic                         busy,
  output logic [MAX_COLS*COL_BITS-1:0] word_bits
);
  logic [CNT_W-1:0] col_q, col_d;
  logic             col_en;

  assign word_done = take && (last_in || (col_q == last_col));
  assign busy      = col_q != '0;
  assign col_en    = clr || take;

  always_comb begin
    if (clr || word_done) col_d = '0;
    else if (take)        col_d = col_q + 1'b1;
    else                  col_d = col_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      col_q <= '0;
    else if (col_en) col_q <= col_d;
  end

  for (genvar c = 0; c < MAX_COLS; c++) begin : g_slot
    logic [COL_BITS-1:0] q, d;
    logic                hit;

    assign hit = take && (col_q == CNT_W'(c));
    assign word_bits[c*COL_BITS +: COL_BITS] = hit ? col_in : q;

    always_comb begin
      if (clr || word_done) d = '0;
      else if (hit)         d = col_in;
      else                  d = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (col_en) q <= d;
    end
  end
endmodule

// File: rtl/vtile_packer.sv
module vtile_packer
  import vtile_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int ROWS     = 4,
  parameter int WORD_W   = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_valid,
  input  logic [DESC_W-1:0]        cfg_desc,
  output logic                     cfg_err,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ROWS*SAMPLE_W-1:0] in_col,
  input  logic                     in_last,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [WORD_W-1:0]        out_data,
  output logic                     out_last
);
  localparam int COL_BITS = ROWS * SAMPLE_W;
  localparam int MAX_COLS = WORD_W / COL_BITS;
  localparam int ACC_W    = MAX_COLS * COL_BITS;
  localparam int CNT_W    = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1;

  layout_t          lay;
  logic             ok_q, ok_d, err_q, err_d;
  logic [CNT_W-1:0] lastc_q, lastc_d;
  logic [7:0]       reps_m1;
  logic             busy, idle, cfg_take, take, word_done;
  logic [ACC_W-1:0] word_bits;
  logic             ov_q, ov_d, ol_q, ol_d, out_en;
  logic [WORD_W-1:0] od_q, od_d;

  vtile_desc_check #(.COL_BITS(COL_BITS), .WORD_W(WORD_W)) u_chk_desc (
    .desc (cfg_desc),
    .lay  (lay)
  );

  assign idle     = !busy && !ov_q;
  assign cfg_take = cfg_valid && idle;
  assign in_ready = ok_q && !cfg_take && (!ov_q || out_ready);
  assign take     = in_valid && in_ready;

  vtile_col_accum #(.COL_BITS(COL_BITS), .MAX_COLS(MAX_COLS), .CNT_W(CNT_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cfg_take),
    .take      (take),
    .last_in   (in_last),
    .last_col  (lastc_q),
    .col_in    (in_col),
    .word_done (word_done),
    .busy      (busy),
    .word_bits (word_bits)
  );

  // descriptor next state
  always_comb begin
    reps_m1 = lay.reps - 8'd1;
    ok_d    = lay.legal;
    err_d   = !lay.legal;
    lastc_d = reps_m1[CNT_W-1:0];
  end

  // output stage next state
  always_comb begin
    out_en = word_done || (ov_q && out_ready);
    ov_d   = word_done || (ov_q && !out_ready);
    ol_d   = word_done ? in_last : ol_q;
    od_d   = word_done ? WORD_W'(word_bits) : od_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      lastc_q <= '0;
    end else if (cfg_take) begin
      ok_q    <= ok_d;
      err_q   <= err_d;
      lastc_q <= lastc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ol_q <= 1'b0;
      od_q <= '0;
    end else if (out_en) begin
      ov_q <= ov_d;
      ol_q <= ol_d;
      od_q <= od_d;
    end
  end

  assign cfg_err   = err_q;
  assign out_valid = ov_q;
  assign out_last  = ol_q;
  assign out_data  = od_q;
endmodule

// File: rtl/vtile_packer_chk.sv
module vtile_packer_chk
  import vtile_pkg::*;
#(
  parameter int WORD_W = 128,
  parameter int IN_W   = 40,
  parameter int ACC_W  = 120
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_take,
  input logic [DESC_W-1:0] cfg_desc,
  input logic              cfg_err,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_last
);
  AST_DIR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take && (cfg_desc[7:0] != DIR_VERT4) |=> cfg_err); // R1
  AST_RSVD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take && (|(cfg_desc & RSVD_MASK)) |=> cfg_err); // R2
  AST_CMP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take && cfg_desc[CMP_BIT] |=> cfg_err); // R3
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !in_ready); // R4
  AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data >> ACC_W) == '0)); // R7
  AST_LAST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> out_valid && out_last); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R10
  AST_CFG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take |-> !in_ready); // R11
endmodule

bind vtile_packer vtile_packer_chk #(
  .WORD_W (WORD_W),
  .IN_W   (COL_BITS),
  .ACC_W  (ACC_W)
) u_packer_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_take  (cfg_take),
  .cfg_desc  (cfg_desc),
  .cfg_err   (cfg_err),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/sim_vtile_packer.sv
module sim_vtile_packer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         cfg_valid = 1'b0;
  logic [63:0]  cfg_desc = '0;
  logic         cfg_err;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [39:0]  in_col = '0;
  logic         in_last = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_last;

  vtile_packer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_desc(cfg_desc), .cfg_err(cfg_err),
    .in_valid(in_valid), .in_ready(in_ready), .in_col(in_col), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [127:0] exp_w[$];
  logic         exp_l[$];
  int m_reps = 3;
  int m_pos = 0;
  logic [127:0] m_word = '0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? (lfsr[0] | lfsr[3]) : 1'b0;
  end

  logic [127:0] held_d;
  logic         held_l;
  bit           held = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held)
        chk(out_valid && out_data == held_d && out_last == held_l, "R10 stalled word held", out_data, held_d);
      held   = out_valid && !out_ready;
      held_d = out_data;
      held_l = out_last;
      if (out_valid && out_ready) begin
        if (exp_w.size() == 0) chk(1'b0, "R10 unexpected word", out_data, '0);
        else begin
          logic [127:0] ew;
          logic el;
          ew = exp_w.pop_front();
          el = exp_l.pop_front();
          chk(out_data == ew, "R6 R8 packed word", out_data, ew);
          chk((out_data >> 120) == '0, "R7 top bits zero", out_data >> 120, '0);
          chk(out_last == el, "R9 out_last", 128'(out_last), 128'(el));
        end
      end
    end
  end

  function automatic logic [9:0] smp(input int i, input int r);
    return 10'((i * 37 + r * 101 + 5) & 1023);
  endfunction

  function automatic logic [63:0] mk(input int dir, input int reps, input int pad);
    return 64'(dir & 255) | (64'(reps & 255) << 8) | (64'(pad & 15) << 16);
  endfunction

  task automatic apply_cfg(input logic [63:0] d, input bit exp_err, input string tag);
    cfg_valid = 1'b1;
    cfg_desc  = d;
    #1;
    chk(in_ready == 1'b0, "R11 no input in load cycle", 128'(in_ready), '0);
    @(negedge clk);
    cfg_valid = 1'b0;
    #1;
    chk(cfg_err == exp_err, tag, 128'(cfg_err), 128'(exp_err));
    chk(in_ready == !exp_err, "R4 in_ready vs error", 128'(in_ready), 128'(!exp_err));
  endtask

  task automatic send_col(input logic [39:0] c, input bit last);
    in_valid = 1'b1;
    in_col   = c;
    in_last  = last;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic push_col(input int i, input bit last);
    logic [39:0] c;
    for (int r = 0; r < 4; r++) begin
      c[r*10 +: 10] = smp(i, r);
      m_word[(4*m_pos + r)*10 +: 10] = smp(i, r);
    end
    m_pos++;
    if (m_pos == m_reps || last) begin
      exp_w.push_back(m_word);
      exp_l.push_back(last);
      m_word = '0;
      m_pos = 0;
    end
    send_col(c, last);
  endtask

  task automatic drain();
    while (exp_w.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R10 actual=hung expected=drained");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(in_ready == 0 && out_valid == 0 && cfg_err == 0, "R5 reset state",
        {out_valid, cfg_err, in_ready}, '0);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 0, "R5 no output before config", 128'(out_valid), '0);

    for (int d = 0; d < 256; d++) apply_cfg(mk(d, 3, 8), d != 1, "R1 scan select");
    for (int b = 20; b < 56; b++)
      apply_cfg(mk(1, 3, 8) | (64'h1 << b), 1'b1, (b == 36) ? "R3 compressed flag" : "R2 reserved bit");
    for (int rp = 0; rp < 256; rp++)
      for (int pd = 0; pd < 16; pd++)
        apply_cfg(mk(1, rp, pd), !(rp >= 1 && rp * 40 + pd <= 128), "R4 size rule");

    // full words, random backpressure
    apply_cfg(mk(1, 3, 8), 1'b0, "R4 rep3 pad8");
    m_reps = 3;
    ready_mode = 1;
    for (int i = 0; i < 30; i++) push_col(i, i == 29);
    drain();
    for (int i = 0; i < 7; i++) push_col(i + 100, i == 6);
    drain();

    apply_cfg(mk(1, 1, 0), 1'b0, "R4 rep1 pad0");
    m_reps = 1;
    for (int i = 0; i < 10; i++) push_col(i + 300, i == 9);
    drain();

    ready_mode = 0;
    apply_cfg(mk(1, 2, 15), 1'b0, "R4 rep2 pad15");
    m_reps = 2;
    for (int i = 0; i < 5; i++) push_col(i + 400, i == 4);
    drain();

    // descriptor ignored mid-word
    apply_cfg(mk(1, 3, 8), 1'b0, "R4 rep3 pad8 again");
    m_reps = 3;
    push_col(500, 1'b0);
    cfg_valid = 1'b1; cfg_desc = mk(1, 1, 0);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_desc = mk(0, 3, 8);
    @(negedge clk);
    cfg_valid = 1'b0;
    #1;
    chk(cfg_err == 0 && in_ready == 1, "R11 ignored while partial", {cfg_err, in_ready}, 128'b01);
    push_col(501, 1'b0);
    push_col(502, 1'b0);
    drain();

    // descriptor ignored while a word is held
    ready_mode = 2;
    @(negedge clk);
    for (int i = 0; i < 3; i++) push_col(600 + i, 1'b0);
    repeat (2) @(negedge clk);
    cfg_valid = 1'b1; cfg_desc = mk(7, 3, 8);
    @(negedge clk);
    cfg_valid = 1'b0;
    #1;
    chk(cfg_err == 0 && out_valid == 1, "R11 ignored while held", {cfg_err, out_valid}, 128'b01);
    ready_mode = 0;
    drain();
    apply_cfg(mk(7, 3, 8), 1'b1, "R11 loaded once idle");
    chk(exp_w.size() == 0, "R10 all words delivered", 128'(exp_w.size()), '0);
    finish_run();
  end
endmodule